// File: doc/BRIEF.md
# GPIO Pin Event Interrupt and Wake Detector

This block watches a bank of already-synchronised GPIO inputs and turns configured pin activity into interrupt and wake requests. Every pin has its own detection mode. In edge mode, rising edges, falling edges or both raise an event. In level mode, an active-high or active-low level raises an event. Each event sets a sticky per-pin status bit that software clears by writing 1. A per-pin enable decides which status bits drive the single combined interrupt line.

A second pair of registers records wake events. A wake-status bit is set only for pins whose wake-enable bit is 1. All registers hold 32 pins per word. Each register type starts at a fixed base address, and later banks of 32 pins follow at 4-byte steps. The block sits on a simple one-cycle register bus: writes take effect on the clock edge, and read data is registered one cycle after the request.

Top module: `gpio_irq_wake_ctrl`

## Requirements
- R1: After the synchronous reset, every configuration register reads 0, both status registers read 0, and `irq_out` and `wake_out` are low.
- R2: Register bases are: rising enable 0x064, falling enable 0x07C, interrupt enable 0x0AC, interrupt status 0x0C4, level-mode select 0x300, level polarity 0x318, wake enable 0x400, wake status 0x418. Pin p uses the word at base + 4*(p/32), bit p%32. The configuration registers read back the value written, and read data appears one cycle after the read request.
- R3: With its level-mode bit at 0, a pin raises an event when its input differs from its value one clock earlier. A 0-to-1 change raises an event when the rising-enable bit is 1, and a 1-to-0 change raises one when the falling-enable bit is 1. Both enables may be set at once.
- R4: With its level-mode bit at 1, a pin raises an event on every clock while its input is active. The input is active when it is high and the polarity bit is 0, or when it is low and the polarity bit is 1. In this state the status bit sets again even right after a clear.
- R5: An event sets the pin's interrupt-status bit, and the bit stays set until a write of 1 to that bit position. Writing 0 leaves the bit unchanged, and a write never sets a bit.
- R6: `irq_out` is the registered OR, over all pins, of interrupt status AND interrupt enable. It follows the status one clock later.
- R7: An event sets a wake-status bit only when the pin's wake-enable bit is 1. Wake status clears on a write of 1. `wake_out` is the registered OR of all wake-status bits.
- R8: If a pin's polarity is written first and its level-mode bit afterwards, no event arises from the old polarity, even while the pin sits at the level the old polarity treated as active.
- R9: A pin with level mode off and both edge enables at 0 raises no event, however its input toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronised GPIO inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |
| wake_out | output | 1 | Combined wake request |

## Verification
The hardest situation to reach is a clear that lands in the same cycle as a fresh event. In level mode this cycle is reached on purpose: the pin is held active while the bench writes 1 to its status bit, and the bench then expects to read the bit back still set. The mode-change ordering also needs a precise setup. The pin is parked at the level the old polarity treats as active, and only then are polarity and level mode written in that order; a read of zero status shows that no spurious event slipped through in between. Edge cases on the second bank use pin 40, which checks the word and bit banking as well.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;

  // register index: configuration fields first, then the two status words
  localparam int F_RISE  = 0;
  localparam int F_FALL  = 1;
  localparam int F_LVL   = 2;
  localparam int F_POL   = 3;
  localparam int F_MASK  = 4;
  localparam int F_WMASK = 5;
  localparam int F_STAT  = 6;
  localparam int F_WSTAT = 7;
  localparam int NCFG    = 6;
  localparam int NREG    = 8;

  typedef struct packed {
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] pol;
    logic [WORD_W-1:0] lvl;
    logic [WORD_W-1:0] fall;
    logic [WORD_W-1:0] rise;
  } bank_cfg_t;

  function automatic int reg_base(input int f);
    case (f)
      F_RISE:  return 'h064;
      F_FALL:  return 'h07C;
      F_LVL:   return 'h300;
      F_POL:   return 'h318;
      F_MASK:  return 'h0AC;
      F_WMASK: return 'h400;
      F_STAT:  return 'h0C4;
      default: return 'h418;
    endcase
  endfunction

  // bits of bank b that map to real pins
  function automatic logic [WORD_W-1:0] bank_valid(input int n_pins, input int b);
    int rem;
    rem = n_pins - b * WORD_W;
    if (rem >= WORD_W) return '1;
    return (WORD_W'(1) << rem) - WORD_W'(1);
  endfunction
endpackage

// File: rtl/gpio_irq_cfg_bank.sv
module gpio_irq_cfg_bank
  import gpio_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCFG-1:0]      we,
  input  logic [WORD_W-1:0]    wdata,
  output bank_cfg_t            cfg
);
  logic [NCFG-1:0][WORD_W-1:0] q;

  for (genvar f = 0; f < NCFG; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)        q[f] <= '0;
      else if (we[f]) q[f] <= wdata & VALID;
    end
  end

  assign cfg.rise  = q[F_RISE];
  assign cfg.fall  = q[F_FALL];
  assign cfg.lvl   = q[F_LVL];
  assign cfg.pol   = q[F_POL];
  assign cfg.mask  = q[F_MASK];
  assign cfg.wmask = q[F_WMASK];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic [WORD_W-1:0] pin,
  input  bank_cfg_t         cfg,
  output logic [WORD_W-1:0] evt
);
  logic [WORD_W-1:0] prev;

  // one-clock history; no reset needed, status is held in reset meanwhile
  always_ff @(posedge clk) prev <= pin;

  for (genvar i = 0; i < WORD_W; i++) begin : g_pin
    logic edge_hit, lvl_hit;
    assign edge_hit = (cfg.rise[i] & pin[i] & ~prev[i]) |
                      (cfg.fall[i] & ~pin[i] & prev[i]);
    assign lvl_hit  = pin[i] ^ cfg.pol[i];
    assign evt[i]   = cfg.lvl[i] ? lvl_hit : edge_hit;
  end
endmodule

// File: rtl/gpio_irq_status_bank.sv
module gpio_irq_status_bank
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] evt,
  input  logic [WORD_W-1:0] wmask,
  input  logic [WORD_W-1:0] clr_stat,
  input  logic [WORD_W-1:0] clr_wake,
  output logic [WORD_W-1:0] stat,
  output logic [WORD_W-1:0] wstat
);
  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      wstat <= '0;
    end else begin
      stat  <= (stat  & ~clr_stat) | evt;
      wstat <= (wstat & ~clr_wake) | (evt & wmask);
    end
  end
endmodule

// File: rtl/gpio_irq_wake_ctrl.sv
module gpio_irq_wake_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                irq_out,
  output logic                wake_out
);
  localparam int NBANK = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PADW  = NBANK * WORD_W;

  logic [PADW-1:0]                       pin_pad;
  logic [NBANK-1:0][NREG-1:0]            hit;
  logic [NBANK-1:0][NREG-1:0][WORD_W-1:0] regview;
  logic [PADW-1:0]                       stat_flat, wstat_flat, mask_flat, wmask_flat;
  logic [WORD_W-1:0]                     rd_mux;

  assign pin_pad = PADW'(pin_in);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_cfg_t         cfg;
    logic [WORD_W-1:0] evt, stat, wstat, clr_s, clr_w;

    for (genvar f = 0; f < NREG; f++) begin : g_dec
      assign hit[b][f] = (bus_addr == ADDR_W'(reg_base(f) + 4 * b));
    end

    gpio_irq_cfg_bank #(.VALID(bank_valid(NUM_PINS, b))) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .we    (bus_wr ? hit[b][NCFG-1:0] : '0),
      .wdata (bus_wdata),
      .cfg   (cfg)
    );

    gpio_irq_detect u_det (
      .clk (clk),
      .pin (pin_pad[b*WORD_W +: WORD_W]),
      .cfg (cfg),
      .evt (evt)
    );

    assign clr_s = (bus_wr && hit[b][F_STAT])  ? bus_wdata : '0;
    assign clr_w = (bus_wr && hit[b][F_WSTAT]) ? bus_wdata : '0;

    gpio_irq_status_bank u_sts (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt),
      .wmask    (cfg.wmask),
      .clr_stat (clr_s),
      .clr_wake (clr_w),
      .stat     (stat),
      .wstat    (wstat)
    );

    assign regview[b] = {wstat, stat, cfg.wmask, cfg.mask, cfg.pol,
                         cfg.lvl, cfg.fall, cfg.rise};

    assign stat_flat [b*WORD_W +: WORD_W] = stat;
    assign wstat_flat[b*WORD_W +: WORD_W] = wstat;
    assign mask_flat [b*WORD_W +: WORD_W] = cfg.mask;
    assign wmask_flat[b*WORD_W +: WORD_W] = cfg.wmask;
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++)
      for (int f = 0; f < NREG; f++)
        if (hit[b][f]) rd_mux = regview[b][f];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      wake_out  <= 1'b0;
    end else begin
      irq_out  <= |(stat_flat & mask_flat);
      wake_out <= |wstat_flat;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_irq_wake_ctrl_chk.sv
module gpio_irq_wake_ctrl_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic         irq_out,
  input logic         wake_out,
  input logic [W-1:0] stat,
  input logic [W-1:0] mask,
  input logic [W-1:0] wstat,
  input logic [W-1:0] wmask
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (stat == '0 && wstat == '0 && !irq_out && !wake_out));

  a_r6_irq_raised: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |=> irq_out);

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & mask)) |=> !irq_out);

  a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
    ((~stat & $past(stat)) != '0) |-> $past(bus_wr));

  a_r7_wake_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (wstat & ~$past(wstat) & ~$past(wmask)) == '0);

  a_r7_wake_follows: assert property (@(posedge clk) disable iff (rst)
    (wstat != '0) |=> wake_out);
endmodule

bind gpio_irq_wake_ctrl gpio_irq_wake_ctrl_chk #(.W(PADW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .irq_out  (irq_out),
  .wake_out (wake_out),
  .stat     (stat_flat),
  .mask     (mask_flat),
  .wstat    (wstat_flat),
  .wmask    (wmask_flat)
);

// File: tb/gpio_irq_wake_ctrl_test.sv
module gpio_irq_wake_ctrl_test;
  localparam int NP = 64;
  localparam logic [11:0] A_RISE = 12'h064, A_FALL = 12'h07C, A_MASK = 12'h0AC,
                          A_STAT = 12'h0C4, A_LVL  = 12'h300, A_POL  = 12'h318,
                          A_WEN  = 12'h400, A_WST  = 12'h418;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out, wake_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_wake_ctrl #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .wake_out(wake_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pin_in[p] = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(A_STAT, '1); wr(A_STAT + 4, '1); wr(A_WST, '1); wr(A_WST + 4, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [11:0] regs [8] = '{A_RISE, A_FALL, A_MASK, A_STAT, A_LVL, A_POL, A_WEN, A_WST};
    foreach (regs[i]) begin
      rd(regs[i], d); check("R1 reset register", d, 0);
    end
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 wake_out", 32'(wake_out), 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(A_POL + 4, 32'hA5A5_0001); rd(A_POL + 4, d);
    check("R2 readback bank1 polarity", d, 32'hA5A5_0001);
    rd(A_POL, d); check("R2 bank0 untouched", d, 0);
    wr(A_POL + 4, 0);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    wr(A_RISE, 32'h20);
    set_pin(5, 1); rd(A_STAT, d); check("R3 rising edge", d, 32'h20);
    wr(A_STAT, 32'h20);
    set_pin(5, 0); rd(A_STAT, d); check("R3 falling ignored in rising mode", d, 0);
    wr(A_RISE, 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    wr(A_FALL, 32'h80);
    set_pin(7, 1); rd(A_STAT, d); check("R3 rise ignored in falling mode", d, 0);
    set_pin(7, 0); rd(A_STAT, d); check("R3 falling edge", d, 32'h80);
    wr(A_FALL, 0); clear_all();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_RISE + 4, 32'h100); wr(A_FALL + 4, 32'h100);
    set_pin(40, 1); rd(A_STAT + 4, d); check("R3 both, rise on pin 40", d, 32'h100);
    rd(A_STAT, d); check("R2 bank0 clean for pin 40", d, 0);
    wr(A_STAT + 4, 32'h100);
    set_pin(40, 0); rd(A_STAT + 4, d); check("R3 both, fall on pin 40", d, 32'h100);
    wr(A_RISE + 4, 0); wr(A_FALL + 4, 0); clear_all();
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    set_pin(9, 1); set_pin(9, 0); set_pin(9, 1);
    rd(A_STAT, d); check("R9 disabled pin raises nothing", d, 0);
    set_pin(9, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_LVL, 32'h4);
    set_pin(2, 1); rd(A_STAT, d); check("R4 active-high level", d, 32'h4);
    wr(A_STAT, 32'h4); rd(A_STAT, d); check("R4 level re-sets after clear", d, 32'h4);
    set_pin(2, 0); wr(A_STAT, 32'h4); rd(A_STAT, d);
    check("R4 inactive level stays clear", d, 0);
    wr(A_LVL, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_RISE, 32'h20); set_pin(5, 1); wr(A_RISE, 0);
    wr(A_STAT, 32'h0); rd(A_STAT, d); check("R5 write 0 keeps status", d, 32'h20);
    wr(A_STAT, 32'h0000_0F00); rd(A_STAT, d); check("R5 write never sets", d, 32'h20);
    wr(A_STAT, 32'h20); rd(A_STAT, d); check("R5 write 1 clears", d, 0);
    set_pin(5, 0);
  endtask

  task automatic t_mask();
    wr(A_RISE, 32'h20); set_pin(5, 1); wr(A_RISE, 0);
    repeat (2) @(negedge clk);
    check("R6 disabled status keeps irq low", 32'(irq_out), 0);
    wr(A_MASK, 32'h20); repeat (2) @(negedge clk);
    check("R6 enabled status raises irq", 32'(irq_out), 1);
    wr(A_STAT, 32'h20); repeat (2) @(negedge clk);
    check("R6 cleared status drops irq", 32'(irq_out), 0);
    wr(A_MASK, 0); set_pin(5, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(A_RISE, 32'h12); wr(A_WEN, 32'h2);
    @(negedge clk); pin_in[1] = 1'b1; pin_in[4] = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_WST, d); check("R7 wake only for enabled pin", d, 32'h2);
    rd(A_STAT, d); check("R7 interrupt status for both pins", d, 32'h12);
    check("R7 wake_out high", 32'(wake_out), 1);
    wr(A_WST, 32'h2); rd(A_WST, d); check("R7 wake W1C", d, 0);
    @(negedge clk); check("R7 wake_out low", 32'(wake_out), 0);
    wr(A_RISE, 0); wr(A_WEN, 0); pin_in[1] = 1'b0; pin_in[4] = 1'b0; clear_all();
  endtask

  task automatic t_order();
    logic [31:0] d;
    set_pin(3, 1);
    wr(A_POL, 32'h8); wr(A_LVL, 32'h8);
    repeat (2) @(negedge clk);
    rd(A_STAT, d); check("R8 polarity then mode, no spurious event", d, 0);
    set_pin(3, 0); rd(A_STAT, d); check("R4 active-low level", d, 32'h8);
    wr(A_LVL, 0); wr(A_POL, 0); clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_rising();
    t_falling();
    t_both();
    t_ignored();
    t_level();
    t_w1c();
    t_mask();
    t_wake();
    t_order();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule